// File: doc/BRIEF.md
# Two-Channel Sequential Break Sequencer

This block merges the match pulses of two breakpoint comparators, channel A and channel B, into one break request pulse. In OR mode, a match on either channel requests a break one cycle later. In sequential mode, channel A first arms the block. A break is then requested only by a channel B match that comes in a later cycle. Clearing the mode bit drops any pending arming.

A programmable execution count refines sequential mode. When the count is non-zero, each qualifying B match counts it down. The break fires on the qualifying B match seen while the count is 1. A count of 0 turns counting off, so the first qualifying B match fires. All outputs are registered, and reset is synchronous and active high.

Top module: `brk_seq_top`

## Requirements
- R1: After synchronous reset, `brk_req`, `armed` and `exec_cnt` are all 0.
- R2: With `seq_en`=0, `brk_req` is high in the cycle after a cycle where `hit_a` or `hit_b` is high. It is low in the cycle after a cycle with neither, so each match gives a one-cycle pulse.
- R3: With `seq_en`=1, a `hit_a` pulse sets `armed` to 1 from the next cycle, unless that same cycle fires a break.
- R4: With `seq_en`=1 and `armed`=0, a `hit_b` pulse produces no break and leaves `armed` at 0.
- R5: With `seq_en`=1 and `armed`=0, `hit_a` and `hit_b` in the same cycle produce no break, and the block ends up armed.
- R6: A cycle with `seq_en`=0 clears `armed`. A later B match in sequential mode then produces no break.
- R7: With `seq_en`=1, `armed`=1 and `exec_cnt`=0, a `hit_b` pulse raises `brk_req` in the next cycle.
- R8: With `seq_en`=1, `armed`=1 and `exec_cnt` greater than 1, a `hit_b` pulse gives no break, lowers `exec_cnt` by 1 and keeps `armed` at 1.
- R9: With `seq_en`=1, `armed`=1 and `exec_cnt`=1, a `hit_b` pulse raises `brk_req` in the next cycle and sets `exec_cnt` to 0.
- R10: A fired sequential break clears `armed`, so a further B match with no new A match gives no break.
- R11: `cnt_load`=1 writes `cnt_val` into `exec_cnt` for the next cycle. It takes priority over a decrement in the same cycle.
- R12: With `seq_en`=0, B matches leave `exec_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_a | input | 1 | Channel A match pulse |
| hit_b | input | 1 | Channel B match pulse |
| seq_en | input | 1 | 1 selects sequential mode, 0 selects OR mode |
| cnt_load | input | 1 | Load strobe for the execution count |
| cnt_val | input | CNT_W | Execution count value to load |
| brk_req | output | 1 | Registered one-cycle break request |
| armed | output | 1 | Channel A match recorded, waiting for channel B |
| exec_cnt | output | CNT_W | Current execution count |

## Verification
The bench builds the block with `CNT_W`=4, which keeps every count value and the full countdown within a few cycles. Loading 3 walks the count through the decrement steps (3 to 2 to 1) and then through the firing step, where the count drops to 0. The bench also covers the zero-count bypass, and a load that lands in the same cycle as a qualifying B match.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;

    typedef enum logic {
        MODE_OR  = 1'b0,
        MODE_SEQ = 1'b1
    } brk_mode_e;

    typedef struct packed {
        logic fire;
        logic dec;
        logic disarm;
    } brk_action_t;

    // Per-cycle decision from the current state and the match pulses.
    function automatic brk_action_t brk_decide(
        input brk_mode_e mode,
        input logic      armed,
        input logic      hit_a,
        input logic      hit_b,
        input logic      cnt_zero,
        input logic      cnt_one
    );
        brk_action_t act;
        act = '0;
        if (mode == MODE_OR) begin
            act.fire   = hit_a | hit_b;
            act.disarm = 1'b1;
        end else if (armed && hit_b) begin
            if (cnt_zero || cnt_one) begin
                act.fire   = 1'b1;
                act.disarm = 1'b1;
                act.dec    = cnt_one;
            end else begin
                act.dec    = 1'b1;
            end
        end
        return act;
    endfunction

endpackage

// File: rtl/brk_arm_tracker.sv
module brk_arm_tracker
    import brk_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  brk_mode_e mode,
    input  logic      hit_a,
    input  logic      disarm,
    output logic      armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (disarm)
            armed_q <= 1'b0;
        else if (mode == MODE_SEQ && hit_a)
            armed_q <= 1'b1;
    end

    assign armed = armed_q;

    // R6: leaving sequential mode drops the recorded A match
    p_or_mode_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OR) |=> !armed_q);
endmodule

// File: rtl/brk_exec_counter.sv
module brk_exec_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);

    // R11: a load wins over any decrement
    p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/brk_seq_top.sv
module brk_seq_top
    import brk_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             seq_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    output logic             brk_req,
    output logic             armed,
    output logic [CNT_W-1:0] exec_cnt
);
    brk_mode_e   mode;
    brk_action_t act;
    logic        cnt_zero;
    logic        cnt_one;
    logic        req_q;

    assign mode = seq_en ? MODE_SEQ : MODE_OR;

    always_comb begin
        act = brk_decide(mode, armed, hit_a, hit_b, cnt_zero, cnt_one);
    end

    brk_arm_tracker u_arm (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .hit_a  (hit_a),
        .disarm (act.disarm),
        .armed  (armed)
    );

    brk_exec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (act.dec),
        .count    (exec_cnt),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= act.fire;
    end

    assign brk_req = req_q;

    // R2: OR mode forwards either match one cycle later
    p_or_mode_r2: assert property (@(posedge clk) disable iff (rst)
        !seq_en |=> brk_req == $past(hit_a | hit_b));

    // R4: no recorded A match means no sequential break
    p_unarmed_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !armed) |=> !brk_req);

    // R8: count above one steps down and holds off the break
    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_en && armed && hit_b && exec_cnt > CNT_W'(1) && !cnt_load)
        |=> (!brk_req && armed && exec_cnt == $past(exec_cnt) - CNT_W'(1)));

    // R10: a fired sequential break disarms
    p_fire_disarms_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_en && armed && hit_b && exec_cnt <= CNT_W'(1))
        |=> (brk_req && !armed));

    // R12: OR mode never changes the count except by load
    p_or_count_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!seq_en && !cnt_load) |=> $stable(exec_cnt));
endmodule

// File: tb/brk_seq_top_bench.sv
module brk_seq_top_bench;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             hit_a, hit_b, seq_en, cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             brk_req, armed;
    logic [CNT_W-1:0] exec_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    brk_seq_top #(.CNT_W(CNT_W)) u_brk_seq_top (
        .clk(clk), .rst(rst), .hit_a(hit_a), .hit_b(hit_b), .seq_en(seq_en),
        .cnt_load(cnt_load), .cnt_val(cnt_val),
        .brk_req(brk_req), .armed(armed), .exec_cnt(exec_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs for one clock; return after the edge, at the falling edge.
    task automatic cyc(input logic a, input logic b, input logic ld = 0,
                       input logic [CNT_W-1:0] v = '0);
        hit_a = a; hit_b = b; cnt_load = ld; cnt_val = v;
        @(negedge clk);
        hit_a = 0; hit_b = 0; cnt_load = 0; cnt_val = '0;
    endtask

    task automatic t_reset();
        rst = 1; seq_en = 0; hit_a = 0; hit_b = 0; cnt_load = 0; cnt_val = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 brk_req", brk_req, 0);
        chk("R1 armed", armed, 0);
        chk("R1 exec_cnt", exec_cnt, 0);
    endtask

    task automatic t_or_mode();
        seq_en = 0;
        cyc(0, 0, 1, 4'd3);
        chk("R11 load", exec_cnt, 3);
        cyc(1, 0);
        chk("R2 A fires", brk_req, 1);
        cyc(0, 0);
        chk("R2 pulse ends", brk_req, 0);
        cyc(0, 1);
        chk("R2 B fires", brk_req, 1);
        chk("R12 count held", exec_cnt, 3);
        cyc(1, 1);
        chk("R2 both fire", brk_req, 1);
        chk("R6 never armed in OR", armed, 0);
    endtask

    task automatic t_b_first();
        seq_en = 1;
        cyc(0, 0, 1, 4'd0);
        cyc(0, 1);
        chk("R4 no break", brk_req, 0);
        chk("R4 stays unarmed", armed, 0);
    endtask

    task automatic t_same_cycle();
        seq_en = 1;
        cyc(1, 1);
        chk("R5 no break", brk_req, 0);
        chk("R5 armed", armed, 1);
        cyc(0, 0);
        chk("R3 holds armed", armed, 1);
        seq_en = 0;
        cyc(0, 0);
        chk("R6 cleared", armed, 0);
        seq_en = 1;
        cyc(0, 1);
        chk("R6 B after clear", brk_req, 0);
    endtask

    task automatic t_count_zero();
        seq_en = 1;
        cyc(1, 0);
        chk("R3 armed", armed, 1);
        chk("R3 no break on A", brk_req, 0);
        cyc(0, 1);
        chk("R7 fires", brk_req, 1);
        chk("R10 disarmed", armed, 0);
        cyc(0, 1);
        chk("R10 no second break", brk_req, 0);
    endtask

    task automatic t_count_run();
        seq_en = 1;
        cyc(0, 0, 1, 4'd3);
        cyc(1, 0);
        cyc(0, 1);
        chk("R8 no break", brk_req, 0);
        chk("R8 count 2", exec_cnt, 2);
        chk("R8 armed", armed, 1);
        cyc(0, 1);
        chk("R8 count 1", exec_cnt, 1);
        chk("R8 still no break", brk_req, 0);
        cyc(0, 1);
        chk("R9 fires", brk_req, 1);
        chk("R9 count 0", exec_cnt, 0);
        chk("R10 disarmed", armed, 0);
    endtask

    task automatic t_load_priority();
        seq_en = 1;
        cyc(0, 0, 1, 4'd5);
        cyc(1, 0);
        cyc(0, 1, 1, 4'd9);
        chk("R11 load over dec", exec_cnt, 9);
        chk("R11 no break", brk_req, 0);
        chk("R11 still armed", armed, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_or_mode();
        t_b_first();
        t_same_cycle();
        t_count_zero();
        t_count_run();
        t_load_priority();
        finish_run();
    end
endmodule